// File: doc/BRIEF.md
# Serial ADC Control-Byte Sequencer

This block is the digital front end of a serial sampling converter that runs from the host's serial clock. While it is idle it watches the data-in line. The first 1 it sees is taken as the start of a control byte. The next three bits select the input polarity and one of four operating modes. From these the block produces the acquire window and counts the conversion frame. It then sends a 16-bit result, taken from a parallel port, out on data-out, MSB first.

Two of the four modes are conversions, one with a short acquire window and one with a long one. A third mode runs a calibration of fixed length, and a strobe output stays high for as long as it lasts. A new start bit or the shutdown pin cuts the calibration short. The fourth mode runs one conversion and then puts the block to sleep. That conversion keeps the acquire length chosen for the previous one, and the next start bit wakes the block. In the short mode a host needs three 8-bit transfers for one conversion: one to send the control byte and two to read the result.

Top module: `adc_ctl_seq`

## Requirements
In the requirements below, edge 0 is the rising clock edge that samples the start bit, and "after edge k" means during the clock period that follows edge k.
- R1: While reset is low, and once it has been released, `busy`, `acq`, `dout`, `sstrb`, `asleep` and `uni` are all 0.
- R2: While the block is idle or asleep and `shdn_n` is high, a 0 on `din` leaves it idle. The first 1 starts a frame: `busy` and `acq` are 1 and `asleep` is 0 after that edge.
- R3: The control byte is laid out as start bit, then polarity at edge 1 (1 = unipolar, shown on `uni` from then on), then M1 at edge 2, then M0 at edge 3. `din` is ignored at edges 4 to 7 of a conversion frame.
- R4: M1,M0 = 00 (short) gives `acq` high after edges 0 to 5 (6 cycles). `busy` is high after edges 0 to 22 and low after edge 23, so the frame is 24 clocks.
- R5: M1,M0 = 11 (long) gives `acq` high after edges 0 to 13 (14 cycles). `busy` is high after edges 0 to 30 and low after edge 31, so the frame is 32 clocks.
- R6: With A = 6 (short) or 14 (long), `result_i` is captured at edge A+1. `dout` then shows bit 15 after edge A+1 and one lower bit after each following edge, down to bit 0 after edge A+16. At every other time `dout` is 0.
- R7: M1,M0 = 01 starts a calibration. `busy` drops and `sstrb` rises after edge 3. `sstrb` stays high for exactly `CAL_CYCLES` cycles and then falls, leaving the block idle.
- R8: During a calibration, a 1 on `din` ends it at that edge and counts as the start bit of a new frame. `sstrb` is 0 and `busy` is 1 after that edge.
- R9: `shdn_n` low ends any frame or calibration at the next edge, with every output except `uni` at 0. Start bits are ignored for as long as it stays low.
- R10: M1,M0 = 10 runs one conversion with the acquire length of the most recent short or long frame, then raises `asleep`. `asleep` stays high until the next start bit.
- R11: A conversion with M1,M0 = 10 that no short or long frame has preceded since reset uses the short length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| shdn_n | input | 1 | Active-low shutdown pin; aborts activity |
| din | input | 1 | Serial control data in |
| result_i | input | RES_W | Conversion code to be shifted out |
| dout | output | 1 | Serial result out, MSB first |
| sstrb | output | 1 | High while a calibration runs |
| acq | output | 1 | Acquire window |
| busy | output | 1 | Conversion frame in progress |
| uni | output | 1 | Latched polarity select (1 = unipolar) |
| asleep | output | 1 | Software shutdown in effect |

## Verification
Conversions are swept over walking-one and walking-zero codes, and the short and long modes alternate with both polarity values. The don't-care bits of each control byte are set to non-zero patterns. A wrong bit order, a wrong capture edge or an off-by-one window length shows up in the bits read back. Sleep-mode frames are run straight after reset, after a short frame and after a long frame, including one long frame cut off by the shutdown pin. These runs tell a correctly kept acquire length from one that resets or follows the sleep code. Calibration is run to the end, then cut off by a start bit and then by the shutdown pin, and the high time of the strobe is counted.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_FRAME = 2'b01,
    ST_CAL   = 2'b10,
    ST_SLEEP = 2'b11
  } seq_state_t;

  // Mode field {M1,M0}; the sequencer decodes these values directly.
  typedef enum logic [1:0] {
    MD_SHORT = 2'b00,
    MD_CAL   = 2'b01,
    MD_SLEEP = 2'b10,
    MD_LONG  = 2'b11
  } mode_t;
endpackage

// File: rtl/adcseq_frame_ctr.sv
module adcseq_frame_ctr #(
  parameter int RES_W         = 16,
  parameter int ACQ_SHORT_END = 6,
  parameter int ACQ_EXTRA     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic run_i,
  input  logic long_i,
  output logic bit1_o,
  output logic bit2_o,
  output logic bit3_o,
  output logic acq_o,
  output logic load_o,
  output logic shift_o,
  output logic last_o
);
  localparam int ACQ_LONG_END = ACQ_SHORT_END + ACQ_EXTRA;
  localparam int FRAME_SHORT  = ACQ_SHORT_END + RES_W + 2;
  localparam int FRAME_LONG   = ACQ_LONG_END + RES_W + 2;
  localparam int CNT_W        = $clog2(FRAME_LONG);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] acq_end, load_at, last_at;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)    cnt_d = CNT_W'(1);
    else if (run_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb begin
    acq_end = long_i ? CNT_W'(ACQ_LONG_END) : CNT_W'(ACQ_SHORT_END);
    load_at = acq_end + 1'b1;
    last_at = long_i ? CNT_W'(FRAME_LONG - 1) : CNT_W'(FRAME_SHORT - 1);
  end

  assign bit1_o  = (cnt_q == CNT_W'(1));
  assign bit2_o  = (cnt_q == CNT_W'(2));
  assign bit3_o  = (cnt_q == CNT_W'(3));
  assign acq_o   = (cnt_q <= acq_end);
  assign load_o  = (cnt_q == load_at);
  assign shift_o = (cnt_q > load_at);
  assign last_o  = (cnt_q == last_at);
endmodule

// File: rtl/adcseq_shifter.sv
module adcseq_shifter #(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [RES_W-1:0] data_i,
  output logic             msb_o
);
  logic [RES_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load_i)       sh_d = data_i;
    else if (shift_i) sh_d = {sh_q[RES_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign msb_o = sh_q[RES_W-1];
endmodule

// File: rtl/adcseq_cal_timer.sv
module adcseq_cal_timer #(
  parameter int CAL_CYCLES = 80000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CAL_W = $clog2(CAL_CYCLES + 1);

  logic [CAL_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (run_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == CAL_W'(CAL_CYCLES - 1));
endmodule

// File: rtl/adc_ctl_seq.sv
module adc_ctl_seq
  import adcseq_pkg::*;
#(
  parameter int RES_W         = 16,
  parameter int ACQ_SHORT_END = 6,
  parameter int ACQ_EXTRA     = 8,
  parameter int CAL_CYCLES    = 80000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shdn_n,
  input  logic             din,
  input  logic [RES_W-1:0] result_i,
  output logic             dout,
  output logic             sstrb,
  output logic             acq,
  output logic             busy,
  output logic             uni,
  output logic             asleep
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_m, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  seq_state_t st_q, st_d;
  logic uni_q, uni_d, m1_q, m1_d, long_q, long_d, sd_q, sd_d;
  logic ctr_start, ctr_run;
  logic f_b1, f_b2, f_b3, f_acq, f_load, f_shift, f_last;
  logic cal_clr, cal_run, cal_done;
  logic sh_load, sh_shift, sh_msb;
  mode_t md;

  adcseq_frame_ctr #(
    .RES_W(RES_W), .ACQ_SHORT_END(ACQ_SHORT_END), .ACQ_EXTRA(ACQ_EXTRA)
  ) u_frame (
    .clk(clk), .rst_n(rst_q), .start_i(ctr_start), .run_i(ctr_run),
    .long_i(long_q), .bit1_o(f_b1), .bit2_o(f_b2), .bit3_o(f_b3),
    .acq_o(f_acq), .load_o(f_load), .shift_o(f_shift), .last_o(f_last)
  );

  adcseq_shifter #(.RES_W(RES_W)) u_shift (
    .clk(clk), .rst_n(rst_q), .load_i(sh_load), .shift_i(sh_shift),
    .data_i(result_i), .msb_o(sh_msb)
  );

  adcseq_cal_timer #(.CAL_CYCLES(CAL_CYCLES)) u_cal (
    .clk(clk), .rst_n(rst_q), .clr_i(cal_clr), .run_i(cal_run),
    .done_o(cal_done)
  );

  assign md = mode_t'({m1_q, din});

  always_comb begin
    st_d      = st_q;
    uni_d     = uni_q;
    m1_d      = m1_q;
    long_d    = long_q;
    sd_d      = sd_q;
    ctr_start = 1'b0;
    ctr_run   = 1'b0;
    cal_clr   = 1'b0;
    cal_run   = 1'b0;
    sh_load   = 1'b0;
    sh_shift  = 1'b0;
    if (!shdn_n) begin
      st_d = ST_IDLE;
      sd_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_SLEEP: begin
          if (din) begin
            st_d      = ST_FRAME;
            ctr_start = 1'b1;
            sd_d      = 1'b0;
          end
        end
        ST_FRAME: begin
          ctr_run = 1'b1;
          if (f_b1) uni_d = din;
          if (f_b2) m1_d  = din;
          if (f_b3) begin
            unique case (md)
              MD_SHORT: long_d = 1'b0;
              MD_LONG:  long_d = 1'b1;
              MD_SLEEP: sd_d   = 1'b1;
              MD_CAL: begin
                st_d    = ST_CAL;
                cal_clr = 1'b1;
              end
              default: ;
            endcase
          end
          if (f_load)       sh_load  = 1'b1;
          else if (f_shift) sh_shift = 1'b1;
          if (f_last && !(f_b3 && md == MD_CAL))
            st_d = sd_q ? ST_SLEEP : ST_IDLE;
        end
        ST_CAL: begin
          if (din) begin
            st_d      = ST_FRAME;
            ctr_start = 1'b1;
            sd_d      = 1'b0;
          end else if (cal_done) begin
            st_d = ST_IDLE;
          end else begin
            cal_run = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st_q   <= ST_IDLE;
      uni_q  <= 1'b0;
      m1_q   <= 1'b0;
      long_q <= 1'b0;
      sd_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      uni_q  <= uni_d;
      m1_q   <= m1_d;
      long_q <= long_d;
      sd_q   <= sd_d;
    end
  end

  assign busy   = (st_q == ST_FRAME);
  assign acq    = busy && f_acq;
  assign dout   = busy && f_shift && sh_msb;
  assign sstrb  = (st_q == ST_CAL);
  assign asleep = (st_q == ST_SLEEP);
  assign uni    = uni_q;
endmodule

// File: rtl/adcseq_checker.sv
module adcseq_checker #(
  parameter int ACQ_SHORT_END = 6,
  parameter int ACQ_EXTRA     = 8,
  parameter int CAL_CYCLES    = 80000
) (
  input logic clk,
  input logic rst_n,
  input logic shdn_n,
  input logic din,
  input logic dout,
  input logic sstrb,
  input logic acq,
  input logic busy,
  input logic asleep
);
  logic [7:0]  acq_len;
  logic [31:0] cal_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acq_len <= '0;
      cal_len <= '0;
    end else begin
      acq_len <= acq ? acq_len + 1'b1 : 8'd0;
      cal_len <= sstrb ? cal_len + 1'b1 : 32'd0;
    end
  end

  AST_START_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !sstrb && shdn_n && din) |=> (busy && acq && !asleep)); // R2
  AST_ACQ_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(acq) && busy) |->
      (acq_len == 8'(ACQ_SHORT_END) || acq_len == 8'(ACQ_SHORT_END + ACQ_EXTRA))); // R4 R5
  AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !dout); // R6
  AST_CAL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sstrb) |-> $past(busy)); // R7
  AST_CAL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sstrb |-> (cal_len < 32'(CAL_CYCLES)) && !busy); // R7
  AST_CAL_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (sstrb && shdn_n && din) |=> (busy && !sstrb)); // R8
  AST_SHDN_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |=> (!busy && !sstrb && !asleep && !dout)); // R9
  AST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && shdn_n && din) |=> (busy && !asleep)); // R10
endmodule

bind adc_ctl_seq adcseq_checker #(
  .ACQ_SHORT_END(ACQ_SHORT_END), .ACQ_EXTRA(ACQ_EXTRA), .CAL_CYCLES(CAL_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_q), .shdn_n(shdn_n), .din(din), .dout(dout),
  .sstrb(sstrb), .acq(acq), .busy(busy), .asleep(asleep)
);

// File: tb/tb_adc_ctl_seq.sv
module tb_adc_ctl_seq;
  localparam int RES_W = 16;
  localparam int CAL_N = 40;

  logic clk = 1'b0;
  logic rst_n, shdn_n, din;
  logic [RES_W-1:0] code;
  logic dout, sstrb, acq, busy, uni, asleep;
  int n_run = 0;
  int n_fail = 0;
  logic prev_long;

  always #5 clk = ~clk;

  adc_ctl_seq #(.RES_W(RES_W), .CAL_CYCLES(CAL_N)) dut (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .din(din), .result_i(code),
    .dout(dout), .sstrb(sstrb), .acq(acq), .busy(busy), .uni(uni),
    .asleep(asleep)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // One full conversion frame; expectations follow R3-R6, R10, R11.
  task automatic conv(input logic u, input logic [1:0] m, input logic [3:0] junk,
                      input logic [15:0] val);
    int ae, fr, na, nb, nq, ns;
    logic [15:0] got;
    logic [7:0] cb;
    string rq;
    if (m == 2'b00) prev_long = 1'b0;
    else if (m == 2'b11) prev_long = 1'b1;
    ae = prev_long ? 14 : 6;
    fr = ae + 18;
    rq = (m == 2'b10) ? "R10_R11" : (prev_long ? "R5" : "R4");
    cb = {1'b1, u, m, junk};
    code = val;
    na = 0; nb = 0; nq = 0; ns = 0; got = '0;
    for (int k = 0; k < fr; k++) begin
      din = (k < 8) ? cb[7-k] : 1'b0;
      tick();
      if (k == 0) check(busy && !asleep, "R2 frame start", int'(busy), 1);
      na += int'(acq);
      ns += int'(sstrb);
      if (k < fr - 1) nb += int'(busy);
      else check(!busy, {rq, " frame end"}, int'(busy), 0);
      if (k >= ae + 1 && k <= ae + 16) got = {got[14:0], dout};
      else if (dout) nq++;
    end
    din = 1'b0;
    check(na == ae, {rq, " acquire cycles"}, na, ae);
    check(nb == fr - 1, {rq, " busy cycles"}, nb, fr - 1);
    check(got == val, "R6 result bits", int'(got), int'(val));
    check(nq == 0, "R6 dout quiet", nq, 0);
    check(uni == u, "R3 polarity latch", int'(uni), int'(u));
    check(ns == 0, "R7 no strobe in conversion", ns, 0);
    check(asleep == (m == 2'b10), "R10 sleep after frame", int'(asleep), int'(m == 2'b10));
  endtask

  task automatic cal_begin(input logic u);
    logic [3:0] cb;
    cb = {1'b1, u, 2'b01};
    for (int k = 0; k < 4; k++) begin
      din = cb[3-k];
      tick();
    end
    din = 1'b0;
    check(sstrb && !busy, "R7 strobe rises", int'(sstrb), 1);
    check(uni == u, "R3 polarity in calibration byte", int'(uni), int'(u));
  endtask

  initial begin
    int ns;
    rst_n = 1'b0; shdn_n = 1'b1; din = 1'b0; code = '0; prev_long = 1'b0;
    repeat (3) tick();
    check({busy, acq, dout, sstrb, asleep, uni} == 6'b0, "R1 reset outputs",
          int'({busy, acq, dout, sstrb, asleep, uni}), 0);
    rst_n = 1'b1;
    repeat (3) tick();
    check({busy, acq, dout, sstrb, asleep, uni} == 6'b0, "R1 after release",
          int'({busy, acq, dout, sstrb, asleep, uni}), 0);
    ns = 0;
    for (int k = 0; k < 10; k++) begin
      tick();
      ns += int'(busy);
    end
    check(ns == 0, "R2 zeros stay idle", ns, 0);

    // R11: sleep frame straight after reset uses the short length.
    conv(1'b1, 2'b10, 4'hF, 16'hBEEF);
    ns = 0;
    for (int k = 0; k < 4; k++) begin
      tick();
      ns += int'(asleep);
    end
    check(ns == 4, "R10 stays asleep", ns, 4);
    conv(1'b0, 2'b00, 4'h5, 16'h1234);

    // Walking one / walking zero over both acquire lengths and polarities.
    for (int i = 0; i < 16; i++)
      conv(i[0], i[1] ? 2'b11 : 2'b00, 4'(i), 16'(1 << i));
    for (int i = 0; i < 16; i++)
      conv(~i[0], i[2] ? 2'b11 : 2'b00, ~4'(i), ~16'(1 << i));
    conv(1'b1, 2'b00, 4'hA, 16'h0000);
    conv(1'b0, 2'b11, 4'h3, 16'hFFFF);

    // R10: sleep frames keep the previous length, long then short.
    conv(1'b0, 2'b11, 4'h0, 16'hA5A5);
    conv(1'b1, 2'b10, 4'h9, 16'h5A5A);
    conv(1'b0, 2'b00, 4'h0, 16'h8001);
    conv(1'b0, 2'b10, 4'h6, 16'h7FFE);

    // R7: full calibration.
    cal_begin(1'b1);
    ns = 1;
    for (int k = 0; k < CAL_N + 8; k++) begin
      tick();
      ns += int'(sstrb);
    end
    check(ns == CAL_N, "R7 strobe length", ns, CAL_N);
    check(!busy && !sstrb, "R7 idle after calibration", int'(busy), 0);

    // R8: start bit aborts calibration and begins a frame.
    cal_begin(1'b0);
    repeat (10) tick();
    check(sstrb, "R8 still calibrating", int'(sstrb), 1);
    conv(1'b1, 2'b00, 4'hC, 16'hC3A5);

    // R9: shutdown pin aborts calibration and blocks start bits.
    cal_begin(1'b0);
    repeat (5) tick();
    shdn_n = 1'b0;
    tick();
    check(!sstrb, "R9 calibration aborted", int'(sstrb), 0);
    din = 1'b1;
    ns = 0;
    for (int k = 0; k < 3; k++) begin
      tick();
      ns += int'(busy);
    end
    check(ns == 0, "R9 start ignored while shut down", ns, 0);
    din = 1'b0;
    shdn_n = 1'b1;
    tick();
    check(!busy && !sstrb && !asleep, "R9 idle after release", int'(busy), 0);

    // R9 then R10: long frame aborted after its mode is latched.
    for (int k = 0; k < 6; k++) begin
      din = (k == 0 || k >= 2 && k <= 3) ? 1'b1 : 1'b0;
      tick();
    end
    din = 1'b0;
    check(acq && busy, "R5 long acquire still open", int'(acq), 1);
    shdn_n = 1'b0;
    tick();
    check(!busy && !acq && !dout, "R9 frame aborted", int'(busy), 0);
    shdn_n = 1'b1;
    tick();
    prev_long = 1'b1;
    conv(1'b1, 2'b10, 4'h0, 16'h0F0F);
    conv(1'b0, 2'b00, 4'h0, 16'hF00F);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule